// File: doc/BRIEF.md
# Dual-Buffer Frame Receiver with Destination Filter

This block is the receive half of a small Ethernet MAC. Frames arrive one byte per beat on a valid/ready stream with a last flag. The block checks each frame's destination address and stores accepted frames in one of two equal receive buffers. A CPU reads the buffers through a 32-bit word-addressed register port. Each buffer has a control word. Hardware sets that word's full flag when a frame has been stored, and software clears the flag to hand the buffer back. There is no length register, so software reads the whole buffer. PHY decoding and FCS checking are done elsewhere.

The stream never stalls. Outside reset `in_ready` is high and the block takes one byte every cycle. A frame aimed at a buffer that is still full is consumed and thrown away, and `lost_pulse` reports it. With alternation enabled, the target buffer swaps after each stored frame. Without it, buffer 0 is always the target. `rx_ready` reports whether buffer 0 is free.

Top module: `rxpp_rx_buffer`

## Requirements
- R1: `reg_addr` is a word address. Its top bit selects the buffer, and the last word of each half is that buffer's control word. The control word keeps all 32 written bits. Bit 0 is the full flag S and bit 3 is the interrupt enable I. After reset both control words read 0, the target is buffer 0 and `rx_ready` is 1. Read data appears one cycle after the address is presented.
- R2: A frame whose first byte has bit 7 set is accepted, whatever its other bytes are.
- R3: A frame whose first byte has bit 7 clear is accepted only if its first six bytes equal `station_addr`, with the first byte compared against bits 47:40. Frames shorter than six bytes fail this test. A rejected frame changes no flag and raises no pulse.
- R4: Stored bytes are packed big-endian: byte n goes to word n/4 at bits 31-8*(n%4) downward. In the final partial word, the unused low lanes are zero.
- R5: Once the last byte of an accepted frame has been taken, S of the target buffer is 1. With `pingpong_en` high, the target then swaps to the other buffer.
- R6: `irq_pulse` is high for exactly one cycle, the cycle after the last beat of a stored frame, when that buffer's I bit and `irq_global_en` are both 1. Otherwise it stays low.
- R7: When a frame passes the filter but its target buffer has S=1 at the frame's first byte, the frame is discarded. In that case `lost_pulse` is high for one cycle after the last beat, the buffer contents and flags stay unchanged, and the target does not move. A frame that fails the filter never raises `lost_pulse`.
- R8: Only the first 4*(words per buffer - 1) bytes are stored, and the bytes after them are dropped. The frame is still accepted, and the control word is never overwritten by data.
- R9: `rx_ready` is the inverse of buffer 0's S bit, whatever state buffer 1 is in.
- R10: A CPU write to a control word replaces it, so writing bit 0 as 0 frees the buffer. CPU writes to buffer data words have no effect.
- R11: `in_ready` is 1 at every cycle after reset. A RAM write happens only on an accepted stream beat.
- R12: With `pingpong_en` low, the target buffer index does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream ready, high whenever out of reset |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the last byte of a frame |
| station_addr | input | 48 | Own station address, first byte in bits 47:40 |
| pingpong_en | input | 1 | Alternate buffers after each stored frame |
| irq_global_en | input | 1 | Global interrupt enable |
| reg_we | input | 1 | CPU write strobe |
| reg_addr | input | AW | CPU word address (AW = log2(BUF_BYTES/4)+1) |
| reg_wdata | input | 32 | CPU write data |
| reg_rdata | output | 32 | CPU read data, one cycle after address |
| rx_ready | output | 1 | Buffer 0 free |
| irq_pulse | output | 1 | One-cycle frame-stored interrupt |
| lost_pulse | output | 1 | One-cycle frame-dropped indication |

## Verification
The bench builds the block with BUF_BYTES=32. That gives eight words per buffer, seven of them data, so the receive capacity is 28 bytes. With a buffer this small, a sweep of every frame length from 1 to 32 crosses all four lane alignments of the final word and runs past the truncation edge. Back-to-back frames with alternation on and off walk both buffer targets through stored, dropped and freed states. Filter cases flip single bytes of the destination and shorten the header.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  localparam int FULL_BIT = 0;
  localparam int IEN_BIT  = 3;
  localparam int DEST_LEN = 6;

  // byte i (0 = first on the wire) of a 48-bit station address
  function automatic logic [7:0] station_byte(input logic [47:0] addr, input logic [2:0] i);
    int sh;
    sh = 0;
    if (i < 3'd6) sh = (5 - int'(i)) * 8;
    return addr[sh +: 8];
  endfunction

endpackage

// File: rtl/rxpp_addr_filter.sv
module rxpp_addr_filter
  import rxpp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        last,
  input  logic [7:0]  data,
  input  logic [47:0] station_addr,
  output logic        accept
);

  logic [2:0] cnt_r;
  logic       grp_r;
  logic       eq_r;
  logic       first, byte_ok, grp_eff, eq_eff, hdr_done;

  always_comb begin
    first    = (cnt_r == 3'd0);
    byte_ok  = (cnt_r < 3'(DEST_LEN)) ? (data == station_byte(station_addr, cnt_r)) : 1'b1;
    grp_eff  = first ? data[7] : grp_r;
    eq_eff   = (first ? 1'b1 : eq_r) & byte_ok;
    hdr_done = (cnt_r >= 3'(DEST_LEN - 1));
    accept   = grp_eff | (eq_eff & hdr_done);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r <= '0;
      grp_r <= 1'b0;
      eq_r  <= 1'b0;
    end else if (beat) begin
      if (last) begin
        cnt_r <= '0;
        grp_r <= 1'b0;
        eq_r  <= 1'b0;
      end else begin
        if (cnt_r < 3'(DEST_LEN)) cnt_r <= cnt_r + 3'd1;
        grp_r <= grp_eff;
        eq_r  <= eq_eff;
      end
    end
  end

endmodule

// File: rtl/rxpp_word_packer.sv
module rxpp_word_packer #(
  parameter int WORDS = 512,
  localparam int DATA_BYTES = (WORDS - 1) * 4,
  localparam int IDXW = $clog2(DATA_BYTES + 1),
  localparam int OFFW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat,
  input  logic            last,
  input  logic [7:0]      data,
  input  logic            enable,
  output logic            wr_en,
  output logic [OFFW-1:0] wr_off,
  output logic [31:0]     wr_data
);

  logic [IDXW-1:0] idx_r;
  logic [31:0]     word_r;
  logic            in_room;
  logic [1:0]      lane;

  always_comb begin
    in_room = (idx_r < IDXW'(DATA_BYTES));
    lane    = idx_r[1:0];
    case (lane)
      2'd0:    wr_data = {data, 24'h0};
      2'd1:    wr_data = {word_r[31:24], data, 16'h0};
      2'd2:    wr_data = {word_r[31:16], data, 8'h0};
      default: wr_data = {word_r[31:8], data};
    endcase
    wr_en  = beat & enable & in_room & ((lane == 2'd3) | last);
    wr_off = OFFW'(idx_r >> 2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_r  <= '0;
      word_r <= '0;
    end else if (beat) begin
      if (last) begin
        idx_r  <= '0;
        word_r <= '0;
      end else if (in_room) begin
        idx_r  <= idx_r + IDXW'(1);
        word_r <= wr_data;
      end
    end
  end

  // R8: data never lands on the control word
  a_r8_ctrl_word_safe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_off) < WORDS - 1));

endmodule

// File: rtl/rxpp_dual_ram.sv
module rxpp_dual_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxpp_ctrl.sv
module rxpp_ctrl
  import rxpp_pkg::*;
#(
  parameter int WORDS = 512,
  localparam int OFFW = $clog2(WORDS),
  localparam int AW = OFFW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          last,
  input  logic          accept,
  input  logic          pingpong_en,
  input  logic          irq_global_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic          drop,
  output logic          tgt,
  output logic          is_ctrl,
  output logic [31:0]   ctrl_rd,
  output logic          rx_ready,
  output logic          irq_pulse,
  output logic          lost_pulse
);

  logic [31:0] ctrl_r [2];
  logic        idx_r, active_r, lost_r;
  logic        commit, miss, csel;

  always_comb begin
    drop     = active_r ? lost_r : ctrl_r[idx_r][FULL_BIT];
    commit   = beat & last & accept & ~drop;
    miss     = beat & last & accept & drop;
    csel     = reg_addr[AW-1];
    is_ctrl  = (reg_addr[OFFW-1:0] == {OFFW{1'b1}});
    ctrl_rd  = ctrl_r[csel];
    tgt      = idx_r;
    rx_ready = ~ctrl_r[0][FULL_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r[0]  <= '0;
      ctrl_r[1]  <= '0;
      idx_r      <= 1'b0;
      active_r   <= 1'b0;
      lost_r     <= 1'b0;
      irq_pulse  <= 1'b0;
      lost_pulse <= 1'b0;
    end else begin
      if (beat) begin
        active_r <= ~last;
        if (!active_r) lost_r <= ctrl_r[idx_r][FULL_BIT];
      end
      for (int b = 0; b < 2; b++) begin
        if (reg_we && is_ctrl && (csel == b[0])) ctrl_r[b] <= reg_wdata;
        if (commit && (idx_r == b[0])) ctrl_r[b][FULL_BIT] <= 1'b1;
      end
      if (commit) idx_r <= idx_r ^ pingpong_en;
      irq_pulse  <= commit & ctrl_r[idx_r][IEN_BIT] & irq_global_en;
      lost_pulse <= miss;
    end
  end

  // R6: interrupt only with global enable
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(irq_global_en));

  // R7: a frame is either stored or lost, never both
  a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && lost_pulse));

  // R12: no alternation, no index movement
  a_r12_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !pingpong_en |=> $stable(idx_r));

endmodule

// File: rtl/rxpp_rx_buffer.sv
module rxpp_rx_buffer #(
  parameter int BUF_BYTES = 2048,
  localparam int WORDS = BUF_BYTES / 4,
  localparam int OFFW = $clog2(WORDS),
  localparam int AW = OFFW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic [47:0]   station_addr,
  input  logic          pingpong_en,
  input  logic          irq_global_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          rx_ready,
  output logic          irq_pulse,
  output logic          lost_pulse
);

  logic            ready_r, beat, accept, drop, tgt, is_ctrl;
  logic            ram_we;
  logic [OFFW-1:0] wr_off;
  logic [31:0]     wr_data, ram_q, ctrl_rd, ctrl_q;
  logic            rd_ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_r <= 1'b0;
    else        ready_r <= 1'b1;
  end

  assign in_ready = ready_r;
  assign beat     = in_valid & ready_r;

  rxpp_addr_filter u_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat         (beat),
    .last         (in_last),
    .data         (in_data),
    .station_addr (station_addr),
    .accept       (accept)
  );

  rxpp_word_packer #(.WORDS(WORDS)) u_packer (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat),
    .last    (in_last),
    .data    (in_data),
    .enable  (~drop),
    .wr_en   (ram_we),
    .wr_off  (wr_off),
    .wr_data (wr_data)
  );

  rxpp_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .beat          (beat),
    .last          (in_last),
    .accept        (accept),
    .pingpong_en   (pingpong_en),
    .irq_global_en (irq_global_en),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .drop          (drop),
    .tgt           (tgt),
    .is_ctrl       (is_ctrl),
    .ctrl_rd       (ctrl_rd),
    .rx_ready      (rx_ready),
    .irq_pulse     (irq_pulse),
    .lost_pulse    (lost_pulse)
  );

  rxpp_dual_ram #(.DEPTH(2 * WORDS)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr ({tgt, wr_off}),
    .wdata (wr_data),
    .raddr (reg_addr),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ctrl_q <= 1'b0;
      ctrl_q    <= '0;
    end else begin
      rd_ctrl_q <= is_ctrl;
      ctrl_q    <= ctrl_rd;
    end
  end

  assign reg_rdata = rd_ctrl_q ? ctrl_q : ram_q;

  // R11: buffer RAM is written only on a taken stream beat
  a_r11_write_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (in_valid && in_ready));

endmodule

// File: tb/rxpp_rx_buffer_test.sv
module rxpp_rx_buffer_test;

  localparam int CLK_PERIOD = 10;
  localparam int BUF_BYTES  = 32;
  localparam int WORDS      = BUF_BYTES / 4;
  localparam int CAP        = (WORDS - 1) * 4;
  localparam int AW         = $clog2(WORDS) + 1;
  localparam int CTRL0      = WORDS - 1;
  localparam int CTRL1      = 2 * WORDS - 1;
  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_ready;
  logic [47:0]   station_addr = STA;
  logic          pingpong_en = 1'b0, irq_global_en = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          rx_ready, irq_pulse, lost_pulse;

  int checks = 0, fails = 0, irq_cnt = 0, lost_cnt = 0;
  logic [7:0] fb [64];

  rxpp_rx_buffer #(.BUF_BYTES(BUF_BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .station_addr(station_addr),
    .pingpong_en(pingpong_en), .irq_global_en(irq_global_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_ready(rx_ready), .irq_pulse(irq_pulse),
    .lost_pulse(lost_pulse)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (irq_pulse) irq_cnt++;
    if (lost_pulse) lost_cnt++;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int seed, input logic [7:0] b0);
    for (int k = 0; k < 64; k++) fb[k] = 8'(seed * 31 + k * 13 + 7);
    fb[0] = b0;
  endtask

  task automatic send(input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[k]; in_last = (k == len - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic check_buf(input string req, input int b, input int len);
    int nb;
    logic [31:0] exp, act;
    nb = (len < CAP) ? len : CAP;
    for (int w = 0; w < (nb + 3) / 4; w++) begin
      exp = '0;
      for (int j = 0; j < 4; j++) begin
        int k;
        k = 4 * w + j;
        exp = {exp[23:0], (k < nb) ? fb[k] : 8'h00};
      end
      reg_read(b * WORDS + w, act);
      check(req, $sformatf("buf%0d word%0d len%0d", b, w, len), act, exp);
    end
  endtask

  task automatic frame_case(input string req, input int len, input int ctrl_a,
                            input logic [31:0] ctrl_exp, input int irq_d, input int lost_d);
    int i0, l0;
    logic [31:0] v;
    i0 = irq_cnt; l0 = lost_cnt;
    send(len);
    check(req, "irq pulses", 32'(irq_cnt - i0), 32'(irq_d));
    check(req, "lost pulses", 32'(lost_cnt - l0), 32'(lost_d));
    reg_read(ctrl_a, v);
    check(req, "control word", v, ctrl_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9 / R11 reset state
    check("R9", "rx_ready after reset", 32'(rx_ready), 32'd1);
    check("R11", "in_ready after reset", 32'(in_ready), 32'd1);
    reg_read(CTRL0, v); check("R1", "ctrl0 reset", v, 32'h0);
    reg_read(CTRL1, v); check("R1", "ctrl1 reset", v, 32'h0);
    check("R1", "no pulses at reset", 32'(irq_cnt + lost_cnt), 32'd0);
    reg_write(CTRL0, 32'hA5A5_0000); reg_read(CTRL0, v);
    check("R1", "ctrl0 keeps written bits", v, 32'hA5A5_0000);
    reg_write(CTRL0, 32'h8); reg_read(CTRL0, v);
    check("R10", "ctrl0 write I", v, 32'h8);

    // R4 / R8 length sweep, broadcast frames, no alternation
    for (int len = 1; len <= BUF_BYTES; len++) begin
      fill(len, 8'hFF);
      frame_case("R5", len, CTRL0, 32'h9, 1, 0);
      check("R9", "rx_ready low when buf0 full", 32'(rx_ready), 32'd0);
      check_buf((len > CAP) ? "R8" : "R4", 0, len);
      reg_read(CTRL1, v); check("R12", "buf1 untouched", v, 32'h0);
      reg_read(CTRL0, v);
      reg_write(CTRL0, 32'h8);
      check("R10", "free restores rx_ready", 32'(rx_ready), 32'd1);
    end

    // R3 exact station match
    fill(90, 8'h02);
    for (int k = 0; k < 6; k++) fb[k] = STA[8*(5-k) +: 8];
    frame_case("R3", 12, CTRL0, 32'h9, 1, 0);
    check_buf("R3", 0, 12);
    reg_write(CTRL0, 32'h8);
    fb[5] = fb[5] ^ 8'h01;
    frame_case("R3", 12, CTRL0, 32'h8, 0, 0);
    fb[5] = fb[5] ^ 8'h01; fb[0] = 8'h03;
    frame_case("R3", 12, CTRL0, 32'h8, 0, 0);
    fb[0] = 8'h02;
    frame_case("R3", 5, CTRL0, 32'h8, 0, 0);
    // R2 group bit with other bytes mismatching
    fill(91, 8'h81);
    frame_case("R2", 9, CTRL0, 32'h9, 1, 0);
    check_buf("R2", 0, 9);

    // R7 full buffer drops frame
    fill(92, 8'hC0);
    frame_case("R7", 10, CTRL0, 32'h9, 0, 1);
    fill(91, 8'h81);
    check_buf("R7", 0, 9);
    fill(93, 8'h04);
    frame_case("R7", 10, CTRL0, 32'h9, 0, 0);
    // R10 data words are read-only
    reg_write(1, 32'hDEAD_BEEF);
    fill(91, 8'h81);
    check_buf("R10", 0, 9);
    reg_write(CTRL0, 32'h8);

    // R6 interrupt gating
    irq_global_en = 1'b0;
    fill(94, 8'hFF);
    frame_case("R6", 7, CTRL0, 32'h9, 0, 0);
    reg_write(CTRL0, 32'h0);
    irq_global_en = 1'b1;
    frame_case("R6", 7, CTRL0, 32'h1, 0, 0);
    reg_write(CTRL0, 32'h8);

    // R5 / R9 / R7 alternating buffers
    pingpong_en = 1'b1;
    reg_write(CTRL1, 32'h8);
    fill(95, 8'hFF);
    frame_case("R5", 6, CTRL0, 32'h9, 1, 0);
    fill(96, 8'hFF);
    frame_case("R5", 14, CTRL1, 32'h9, 1, 0);
    check_buf("R5", 1, 14);
    reg_write(CTRL0, 32'h8);
    check("R9", "rx_ready follows buf0 only", 32'(rx_ready), 32'd1);
    fill(97, 8'hFF);
    frame_case("R5", 3, CTRL0, 32'h9, 1, 0);
    fill(98, 8'hFF);
    frame_case("R7", 11, CTRL1, 32'h9, 0, 1);
    fill(96, 8'hFF);
    check_buf("R7", 1, 14);
    reg_write(CTRL1, 32'h8);
    fill(99, 8'hFF);
    frame_case("R5", 13, CTRL1, 32'h9, 1, 0);
    check_buf("R5", 1, 13);
    check("R11", "in_ready stays high", 32'(in_ready), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule